// File: doc/BRIEF.md
# RGB to YCbCr Colour-Space Converter with Selectable Standard

This block turns a stream of 8-bit red, green and blue samples into 8-bit luma (Y) and chroma (Cb, Cr) samples. It accepts one pixel per clock. It is meant for a video source running at a 74.25 MHz pixel clock for 1280x720 at 60 frames per second. Its outputs go to a 4:2:2 packer. That packer takes Cb on even active pixels and Cr on odd ones, and pairs each with the same pixel's Y. For that reason all three components leave the block on the same cycle.

A static selector picks one of two coefficient sets. The standard-definition set follows the 0.299/0.587/0.114 luma weighting. The high-definition set follows the 0.213/0.715/0.072 weighting. The block applies the selector only on cycles where no valid pixel is presented, so a line never mixes the two matrices. Each component is computed with unsigned 8.8 fixed-point constants. The block adds a half-LSB rounding term, shifts right by eight and saturates the result to 0..255. A chroma bias of 128 is folded into the rounding constant. A valid flag travels with the data through a fixed three-stage pipeline.

Top module: `rgb_ycc_convert`

## Requirements
- R1: With the standard-definition set selected (selector value 0), Y = floor((77·R + 150·G + 29·B + 128) / 256).
- R2: With the high-definition set selected (selector value 1), Y = floor((54·R + 183·G + 19·B + 128) / 256).
- R3: Chroma is Cb = floor((32896 − kr·R − kg·G + 128·B) / 256) and Cr = floor((32896 + 128·R − jg·G − jb·B) / 256). The constants are (kr, kg) = (43, 85) and (jg, jb) = (107, 21) for standard definition, and (29, 99) and (116, 12) for high definition.
- R4: Every result is saturated to 0..255. For example, pure blue (0,0,255) gives Cb = 255 and pure red (255,0,0) gives Cr = 255.
- R5: Any grey input R = G = B = v gives Y = v, Cb = 128 and Cr = 128 in both modes. This covers black (Y = 0) and white (Y = 255).
- R6: Y, Cb, Cr and the output valid all appear exactly 3 clock cycles after the input sample and its valid, on the same cycle.
- R7: The selector is captured only on rising edges where the input valid is low. A change while valid is high has no effect on the coefficient set until an idle cycle follows. After reset the standard-definition set is in force.
- R8: While reset is asserted (active low, synchronous), the output valid and all three outputs are driven to zero on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| std_sel | input | 1 | Coefficient set: 0 standard definition, 1 high definition |
| pix_vld_i | input | 1 | Input sample valid |
| red_i | input | DW | Red sample |
| grn_i | input | DW | Green sample |
| blu_i | input | DW | Blue sample |
| pix_vld_o | output | 1 | Output valid, 3 cycles after pix_vld_i |
| luma_o | output | DW | Y result |
| cb_o | output | DW | Cb result |
| cr_o | output | DW | Cr result |

## Verification
The bench builds the converter with its default 8-bit sample width. This keeps a 16-level grid per channel (0, 17, ..., 255) small enough to stream all 4096 colour triples through each coefficient set back to back. That grid reaches the channel extremes where chroma saturates, the full grey axis, and both endpoints of every multiplier. Directed sequences then toggle the selector in the middle of a valid burst and across idle gaps, and drive valid pixels while reset is held.

// File: rtl/ycc_pkg.sv
// Package: shared coefficient types and the two fixed-point matrices.
// Assumes 8 fractional bits; every constant is a magnitude (signs live in
// the lane parameters), chosen so each luma row sums to 256 and each chroma
// row balances to zero for grey input.
package ycc_pkg;

    localparam int CW   = 8;   // coefficient width (magnitude)
    localparam int FRAC = 8;   // fractional bits of every coefficient

    typedef logic [CW-1:0] coef_t;

    typedef struct packed {
        coef_t ka;   // weight on red
        coef_t kb;   // weight on green
        coef_t kc;   // weight on blue
    } coef_row_t;

    typedef struct packed {
        coef_row_t y;
        coef_row_t cb;
        coef_row_t cr;
    } coef_set_t;

    // Returns the matrix for the requested standard (1 = high definition).
    function automatic coef_set_t coef_pick(input logic hd);
        coef_set_t s;
        if (hd) begin
            s.y  = '{ka: 8'd54,  kb: 8'd183, kc: 8'd19};
            s.cb = '{ka: 8'd29,  kb: 8'd99,  kc: 8'd128};
            s.cr = '{ka: 8'd128, kb: 8'd116, kc: 8'd12};
        end else begin
            s.y  = '{ka: 8'd77,  kb: 8'd150, kc: 8'd29};
            s.cb = '{ka: 8'd43,  kb: 8'd85,  kc: 8'd128};
            s.cr = '{ka: 8'd128, kb: 8'd107, kc: 8'd21};
        end
        return s;
    endfunction

endpackage

// File: rtl/ycc_mode_hold.sv
// Module: ycc_mode_hold
// Holds the active coefficient-set selector. The external selector is
// copied only on edges where no valid pixel is presented, so a burst of
// valid pixels always sees one matrix. Resets to the standard-definition set.
module ycc_mode_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic vld_i,
    output logic mode_o
);

    logic mode_q;

    // Capture the selector on idle cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else if (!vld_i)
            mode_q <= sel_i;
    end

    assign mode_o = mode_q;

    // R7: a valid cycle never lets the held selector move.
    a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> $stable(mode_q));

endmodule

// File: rtl/ycc_valid_delay.sv
// Module: ycc_valid_delay
// Delays the pixel-valid flag by DEPTH cycles so it lines up with the
// arithmetic pipeline. Assumes DEPTH >= 2. Cleared by reset.
module ycc_valid_delay #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    output logic vld_o
);

    logic [DEPTH-1:0] sh_q;

    // Shift the valid flag one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else
            sh_q <= {sh_q[DEPTH-2:0], vld_i};
    end

    assign vld_o = sh_q[DEPTH-1];

endmodule

// File: rtl/ycc_lane.sv
// Module: ycc_lane
// One output component: three products (stage 2), then signed sum, bias,
// half-LSB rounding, arithmetic shift and saturation (stage 3).
// Assumes the operands arrive already registered (stage 1) in the parent.
// Coefficients are unsigned magnitudes; NEG_* picks the sign of each term.
module ycc_lane #(
    parameter int DW     = 8,
    parameter int CW     = 8,
    parameter int FRAC   = 8,
    parameter int OFFSET = 0,
    parameter bit NEG_A  = 1'b0,
    parameter bit NEG_B  = 1'b0,
    parameter bit NEG_C  = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] x_a,
    input  logic [DW-1:0] x_b,
    input  logic [DW-1:0] x_c,
    input  logic [CW-1:0] k_a,
    input  logic [CW-1:0] k_b,
    input  logic [CW-1:0] k_c,
    output logic [DW-1:0] res_o
);

    localparam int PW = DW + CW;      // product width
    localparam int SW = PW + 3;       // signed accumulator width
    localparam logic signed [SW-1:0] BIAS =
        SW'((OFFSET << FRAC) + (1 << (FRAC - 1)));
    localparam logic signed [SW-1:0] MAXV = SW'((1 << DW) - 1);

    logic [PW-1:0]        prod_a_q, prod_b_q, prod_c_q;
    logic signed [SW-1:0] ea, eb, ec;
    logic signed [SW-1:0] acc, shf;
    logic [DW-1:0]        clip;
    logic [DW-1:0]        res_q;

    // Stage 2: register the three unsigned products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_a_q <= '0;
            prod_b_q <= '0;
            prod_c_q <= '0;
        end else begin
            prod_a_q <= PW'(x_a) * PW'(k_a);
            prod_b_q <= PW'(x_b) * PW'(k_b);
            prod_c_q <= PW'(x_c) * PW'(k_c);
        end
    end

    assign ea = $signed({{(SW-PW){1'b0}}, prod_a_q});
    assign eb = $signed({{(SW-PW){1'b0}}, prod_b_q});
    assign ec = $signed({{(SW-PW){1'b0}}, prod_c_q});

    // Signed sum with bias and rounding, then shift and saturate.
    always_comb begin
        acc = BIAS + (NEG_A ? -ea : ea) + (NEG_B ? -eb : eb) + (NEG_C ? -ec : ec);
        shf = acc >>> FRAC;
        if (shf < 0)
            clip = '0;
        else if (shf > MAXV)
            clip = '1;
        else
            clip = shf[DW-1:0];
    end

    // Stage 3: register the saturated result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= clip;
    end

    assign res_o = res_q;

endmodule

// File: rtl/rgb_ycc_convert.sv
// Module: rgb_ycc_convert (top)
// Pipelined RGB to YCbCr converter with a selectable coefficient set.
// Stage 1 registers the pixel together with the matrix chosen by the held
// selector; stages 2 and 3 live in three parallel lanes. Latency is three
// cycles for data and valid alike. Assumes DW = 8 for the chroma bias range
// implied by the coefficient package.
module rgb_ycc_convert #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          std_sel,
    input  logic          pix_vld_i,
    input  logic [DW-1:0] red_i,
    input  logic [DW-1:0] grn_i,
    input  logic [DW-1:0] blu_i,
    output logic          pix_vld_o,
    output logic [DW-1:0] luma_o,
    output logic [DW-1:0] cb_o,
    output logic [DW-1:0] cr_o
);

    import ycc_pkg::*;

    localparam int LAT     = 3;
    localparam int NLANE   = 3;
    localparam int CHR_OFS = 1 << (DW - 1);
    // Sign of each term per lane, packed {blue, green, red}: Y, Cb, Cr.
    localparam logic [3*NLANE-1:0] NEG_MAP = {3'b110, 3'b011, 3'b000};

    logic          mode_q;
    logic [DW-1:0] red_s1, grn_s1, blu_s1;
    coef_set_t     coef_s1;
    coef_row_t     row_s1 [NLANE];
    logic [DW-1:0] res    [NLANE];

    ycc_mode_hold u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (std_sel),
        .vld_i  (pix_vld_i),
        .mode_o (mode_q)
    );

    // Stage 1: register the pixel and the matrix it will be multiplied by.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            red_s1  <= '0;
            grn_s1  <= '0;
            blu_s1  <= '0;
            coef_s1 <= '0;
        end else begin
            red_s1  <= red_i;
            grn_s1  <= grn_i;
            blu_s1  <= blu_i;
            coef_s1 <= coef_pick(mode_q);
        end
    end

    assign row_s1[0] = coef_s1.y;
    assign row_s1[1] = coef_s1.cb;
    assign row_s1[2] = coef_s1.cr;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        ycc_lane #(
            .DW     (DW),
            .CW     (CW),
            .FRAC   (FRAC),
            .OFFSET ((i == 0) ? 0 : CHR_OFS),
            .NEG_A  (NEG_MAP[3*i]),
            .NEG_B  (NEG_MAP[3*i+1]),
            .NEG_C  (NEG_MAP[3*i+2])
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .x_a   (red_s1),
            .x_b   (grn_s1),
            .x_c   (blu_s1),
            .k_a   (row_s1[i].ka),
            .k_b   (row_s1[i].kb),
            .k_c   (row_s1[i].kc),
            .res_o (res[i])
        );
    end

    ycc_valid_delay #(.DEPTH(LAT)) u_vld (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (pix_vld_i),
        .vld_o (pix_vld_o)
    );

    assign luma_o = res[0];
    assign cb_o   = res[1];
    assign cr_o   = res[2];

    // Cycles since reset release, saturating; guards the $past(.,3) checks.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            age_q <= '0;
        else if (age_q != 2'd3)
            age_q <= age_q + 2'd1;
    end

    // R6: output valid follows input valid by exactly three cycles.
    a_r6_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (pix_vld_o == $past(pix_vld_i, 3)));

    // R5: a valid grey pixel comes out as Y = level, neutral chroma.
    a_r5_grey_neutral: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q == 2'd3) && $past(pix_vld_i, 3) &&
         ($past(red_i, 3) == $past(grn_i, 3)) && ($past(grn_i, 3) == $past(blu_i, 3)))
        |-> ((luma_o == $past(red_i, 3)) && (cb_o == DW'(CHR_OFS)) && (cr_o == DW'(CHR_OFS))));

    // R8: one edge of reset clears the valid and all three outputs.
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!pix_vld_o && (luma_o == '0) && (cb_o == '0) && (cr_o == '0)));

endmodule

// File: tb/rgb_ycc_convert_bench.sv
// Bench: streams grid sweeps and directed sequences, models the three-cycle
// pipeline with a small history of expected results.
module rgb_ycc_convert_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       std_sel;
    logic       pix_vld_i;
    logic [7:0] red_i, grn_i, blu_i;
    logic       pix_vld_o;
    logic [7:0] luma_o, cb_o, cr_o;

    always #4 clk = ~clk;

    rgb_ycc_convert u_rgb_ycc_convert (
        .clk       (clk),
        .rst_n     (rst_n),
        .std_sel   (std_sel),
        .pix_vld_i (pix_vld_i),
        .red_i     (red_i),
        .grn_i     (grn_i),
        .blu_i     (blu_i),
        .pix_vld_o (pix_vld_o),
        .luma_o    (luma_o),
        .cb_o      (cb_o),
        .cr_o      (cr_o)
    );

    int    checks = 0;
    int    errors = 0;
    bit    h_v  [3];
    int    h_y  [3];
    int    h_cb [3];
    int    h_cr [3];
    string h_ty [3];
    string h_tc [3];
    bit    model_hd;

    function automatic int sat8(input int v);
        if (v < 0)   return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    // Expected Y/Cb/Cr from the requirement formulas.
    task automatic ref_ycc(input bit hd, input int r, input int g, input int b,
                           output int y, output int cb, output int cr);
        int k [9];
        if (hd) k = '{54, 183, 19, 29, 99, 128, 128, 116, 12};
        else    k = '{77, 150, 29, 43, 85, 128, 128, 107, 21};
        y  = sat8((k[0]*r + k[1]*g + k[2]*b + 128) >>> 8);
        cb = sat8((32896 - k[3]*r - k[4]*g + k[5]*b) >>> 8);
        cr = sat8((32896 + k[6]*r - k[7]*g - k[8]*b) >>> 8);
    endtask

    task automatic check_int(input string tag, input string what,
                             input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One pixel clock: check what left the pipe, then present a new input.
    task automatic step(input bit v, input int r, input int g, input int b,
                        input bit m, input string tag);
        int y, cb, cr;
        @(negedge clk);
        check_int("R6", "output valid", int'(pix_vld_o), int'(h_v[2]));
        if (h_v[2]) begin
            check_int(h_ty[2], "luma", int'(luma_o), h_y[2]);
            check_int(h_tc[2], "cb",   int'(cb_o),   h_cb[2]);
            check_int(h_tc[2], "cr",   int'(cr_o),   h_cr[2]);
        end
        for (int i = 2; i > 0; i--) begin
            h_v[i]  = h_v[i-1];  h_y[i]  = h_y[i-1];
            h_cb[i] = h_cb[i-1]; h_cr[i] = h_cr[i-1];
            h_ty[i] = h_ty[i-1]; h_tc[i] = h_tc[i-1];
        end
        ref_ycc(model_hd, r, g, b, y, cb, cr);
        h_v[0] = v; h_y[0] = y; h_cb[0] = cb; h_cr[0] = cr;
        if (tag != "") begin
            h_ty[0] = tag; h_tc[0] = tag;
        end else begin
            h_ty[0] = model_hd ? "R2" : "R1";
            h_tc[0] = "R3";
        end
        if (!v) model_hd = m;
        pix_vld_i = v;
        red_i = r[7:0]; grn_i = g[7:0]; blu_i = b[7:0];
        std_sel = m;
    endtask

    task automatic sweep(input bit hd);
        step(1'b0, 0, 0, 0, hd, "");
        for (int r = 0; r < 16; r++)
            for (int g = 0; g < 16; g++)
                for (int b = 0; b < 16; b++)
                    step(1'b1, r*17, g*17, b*17, hd, "");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; std_sel = 1'b1; pix_vld_i = 1'b1;
        red_i = 8'd200; grn_i = 8'd100; blu_i = 8'd50;
        for (int i = 0; i < 3; i++) begin h_v[i] = 1'b0; h_ty[i] = ""; h_tc[i] = ""; end
        repeat (4) @(negedge clk);
        // R8: valid pixels fed during reset must not surface.
        check_int("R8", "valid in reset", int'(pix_vld_o), 0);
        check_int("R8", "luma in reset",  int'(luma_o), 0);
        check_int("R8", "cb in reset",    int'(cb_o), 0);
        check_int("R8", "cr in reset",    int'(cr_o), 0);
        rst_n = 1'b1; pix_vld_i = 1'b0; std_sel = 1'b0; model_hd = 1'b0;

        // R1, R3: standard-definition grid.
        sweep(1'b0);
        // R2, R3: high-definition grid.
        sweep(1'b1);

        // R4: saturation corners in both modes.
        for (int m = 0; m < 2; m++) begin
            step(1'b0, 0, 0, 0, m[0], "");
            step(1'b1, 0, 0, 255, m[0], "R4");
            step(1'b1, 255, 0, 0, m[0], "R4");
            step(1'b1, 0, 255, 0, m[0], "R4");
            step(1'b1, 255, 0, 255, m[0], "R4");
        end

        // R5: grey axis including black and white.
        for (int m = 0; m < 2; m++) begin
            step(1'b0, 0, 0, 0, m[0], "");
            for (int v = 0; v < 256; v += 5) step(1'b1, v, v, v, m[0], "R5");
            step(1'b1, 255, 255, 255, m[0], "R5");
        end

        // R7: selector change inside a burst is ignored until an idle cycle.
        step(1'b0, 0, 0, 0, 1'b0, "");
        for (int i = 0; i < 5; i++) step(1'b1, 200, 50, 10, 1'b1, "R7");
        step(1'b0, 0, 0, 0, 1'b1, "");
        step(1'b1, 200, 50, 10, 1'b1, "R7");
        step(1'b1, 200, 50, 10, 1'b0, "R7");
        step(1'b0, 0, 0, 0, 1'b0, "");
        step(1'b1, 200, 50, 10, 1'b1, "R7");

        // R6: sparse valid pattern, then drain.
        step(1'b1, 10, 20, 30, 1'b0, "R6");
        step(1'b0, 90, 90, 90, 1'b0, "R6");
        step(1'b1, 40, 220, 5, 1'b0, "R6");
        repeat (4) step(1'b0, 0, 0, 0, 1'b0, "");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule